// File: doc/BRIEF.md
# Interrupt Status Register with Reload-on-Clear

This block holds the interrupt status word of a network controller. The receive and transmit engines raise individual status bits with single-cycle set pulses. Host software acknowledges events by writing ones to the register. A parameterised writable mask decides which bits such a write may clear. The current status word is always visible on the read-data output, and looking at it changes nothing.

A single interrupt request is derived from the status word and a per-bit enable vector. In its default form that request is registered. The block has one side effect. When the host acknowledges the buffers-exhausted condition while that bit is actually set, the block pulses a reload request toward the receive engine for one cycle, so that the engine can fetch a fresh receive resource area. The reload itself happens elsewhere.

Top module: `isr_status_reg`

## Requirements
- R1: After reset the status word, the interrupt request and the reload request are all 0.
- R2: A set pulse raises its status bit, which reads as 1 from the cycle after the pulse. The positions are: packet received at bit 0, transmit done at bit 1, programmable interrupt at bit 2, descriptors exhausted at bit 3, buffers exhausted at bit 4.
- R3: A host write clears every status bit where the write data holds a 1 and the writable mask (default 0x001F) allows it. The clear is visible in the cycle after the write.
- R4: Bits written with 0 keep their value, and status bits 5 to 15 always read 0 whatever is written.
- R5: When a set pulse and a host clear hit the same bit in the same cycle, the bit ends up set.
- R6: A host write with data bit 4 at 1, made while status bit 4 is set, drives the reload request high for exactly the next cycle. The reload request stays low if bit 4 was clear or was written with 0.
- R7: The interrupt request equals the OR over all bits of (status AND enable), registered, so it follows the status and enable values of the previous cycle.
- R8: The status output reflects the register with no side effects. Holding or sampling it never alters state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| host_wr_i | input | 1 | Host write strobe for the status register |
| host_wdata_i | input | 16 | Host write data, ones clear bits |
| rx_pkt_set_i | input | 1 | Packet-received set pulse |
| rx_desc_ex_set_i | input | 1 | Descriptors-exhausted set pulse |
| rx_buf_ex_set_i | input | 1 | Buffers-exhausted set pulse |
| tx_done_set_i | input | 1 | Transmit-done set pulse |
| prog_int_set_i | input | 1 | Programmable-interrupt set pulse |
| irq_en_i | input | 16 | Per-bit interrupt enable |
| status_o | output | 16 | Current status word (read data) |
| irq_o | output | 1 | Registered interrupt request |
| rx_reload_o | output | 1 | One-cycle receive resource reload request |

## Verification
Two functions can land on the same edge: an engine setting a bit and the host clearing that same bit. The case that matters most is the buffers-exhausted bit. There, a host acknowledgement and a fresh exhaustion pulse arrive together. The set must win, and the reload request must still fire, because the bit was set before the write. The bench forces these coincidences both in directed steps and in a long random mix. It judges every cycle against a behavioural model that applies the rule "old value decides reload, set overrides clear".

// File: rtl/isr_pkg.sv
package isr_pkg;
   localparam int unsigned ISR_W = 16;

   typedef struct packed {
      logic pkt_rx;
      logic tx_done;
      logic prog;
      logic desc_ex;
      logic buf_ex;
   } isr_src_t;
endpackage

// File: rtl/isr_src_map.sv
module isr_src_map import isr_pkg::*; #(
   parameter int unsigned WIDTH       = ISR_W,
   parameter int unsigned POS_PKT_RX  = 0,
   parameter int unsigned POS_TX_DONE = 1,
   parameter int unsigned POS_PROG    = 2,
   parameter int unsigned POS_DESC_EX = 3,
   parameter int unsigned POS_BUF_EX  = 4
)(
   input  isr_src_t         src_i,
   output logic [WIDTH-1:0] set_vec_o
);
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      if (b == POS_PKT_RX) begin : g_pkt
         assign set_vec_o[b] = src_i.pkt_rx;
      end else if (b == POS_TX_DONE) begin : g_txd
         assign set_vec_o[b] = src_i.tx_done;
      end else if (b == POS_PROG) begin : g_prg
         assign set_vec_o[b] = src_i.prog;
      end else if (b == POS_DESC_EX) begin : g_dex
         assign set_vec_o[b] = src_i.desc_ex;
      end else if (b == POS_BUF_EX) begin : g_bex
         assign set_vec_o[b] = src_i.buf_ex;
      end else begin : g_none
         assign set_vec_o[b] = 1'b0;
      end
   end
endmodule

// File: rtl/isr_bit_cell.sv
module isr_bit_cell (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni)    q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/isr_reload_detect.sv
module isr_reload_detect #(
   parameter bit ENABLE = 1'b1
)(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wr_i,
   input  logic wbit_i,
   input  logic stat_i,
   output logic req_o
);
   if (ENABLE) begin : g_on
      always_ff @(posedge clk_i) begin
         if (!rst_ni) req_o <= 1'b0;
         else         req_o <= wr_i & wbit_i & stat_i;
      end
   end else begin : g_off
      logic unused_in;
      assign unused_in = clk_i ^ rst_ni ^ wr_i ^ wbit_i ^ stat_i;
      assign req_o = 1'b0;
   end
endmodule

// File: rtl/isr_irq_gen.sv
module isr_irq_gen #(
   parameter int unsigned WIDTH      = 16,
   parameter bit          REGISTERED = 1'b1
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] status_i,
   input  logic [WIDTH-1:0] en_i,
   output logic             irq_o
);
   logic any_pending;
   assign any_pending = |(status_i & en_i);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk_i) begin
         if (!rst_ni) irq_o <= 1'b0;
         else         irq_o <= any_pending;
      end
   end else begin : g_comb
      logic unused_in;
      assign unused_in = clk_i ^ rst_ni;
      assign irq_o = any_pending;
   end
endmodule

// File: rtl/isr_status_reg.sv
module isr_status_reg import isr_pkg::*; #(
   parameter int unsigned      WIDTH       = ISR_W,
   parameter int unsigned      POS_PKT_RX  = 0,
   parameter int unsigned      POS_TX_DONE = 1,
   parameter int unsigned      POS_PROG    = 2,
   parameter int unsigned      POS_DESC_EX = 3,
   parameter int unsigned      POS_BUF_EX  = 4,
   parameter logic [WIDTH-1:0] WR_MASK     = 16'h001F,
   parameter bit               IRQ_REG     = 1'b1
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             host_wr_i,
   input  logic [WIDTH-1:0] host_wdata_i,
   input  logic             rx_pkt_set_i,
   input  logic             rx_desc_ex_set_i,
   input  logic             rx_buf_ex_set_i,
   input  logic             tx_done_set_i,
   input  logic             prog_int_set_i,
   input  logic [WIDTH-1:0] irq_en_i,
   output logic [WIDTH-1:0] status_o,
   output logic             irq_o,
   output logic             rx_reload_o
);
   localparam int unsigned MAXPOS = WIDTH - 1;
   localparam bit RELOAD_ON = WR_MASK[POS_BUF_EX];

   // elaboration-time parameter checks
   if (POS_PKT_RX > MAXPOS || POS_TX_DONE > MAXPOS || POS_PROG > MAXPOS ||
       POS_DESC_EX > MAXPOS || POS_BUF_EX > MAXPOS) begin : g_bad_pos
      $error("isr_status_reg: a source position exceeds WIDTH-1");
   end
   if (POS_PKT_RX == POS_TX_DONE || POS_PKT_RX == POS_PROG ||
       POS_PKT_RX == POS_DESC_EX || POS_PKT_RX == POS_BUF_EX ||
       POS_TX_DONE == POS_PROG || POS_TX_DONE == POS_DESC_EX ||
       POS_TX_DONE == POS_BUF_EX || POS_PROG == POS_DESC_EX ||
       POS_PROG == POS_BUF_EX || POS_DESC_EX == POS_BUF_EX) begin : g_bad_dup
      $error("isr_status_reg: two sources share a bit position");
   end

   isr_src_t         src;
   logic [WIDTH-1:0] set_vec;
   logic [WIDTH-1:0] clr_vec;
   logic [WIDTH-1:0] stat_q;

   assign src.pkt_rx  = rx_pkt_set_i;
   assign src.tx_done = tx_done_set_i;
   assign src.prog    = prog_int_set_i;
   assign src.desc_ex = rx_desc_ex_set_i;
   assign src.buf_ex  = rx_buf_ex_set_i;

   isr_src_map #(
      .WIDTH(WIDTH), .POS_PKT_RX(POS_PKT_RX), .POS_TX_DONE(POS_TX_DONE),
      .POS_PROG(POS_PROG), .POS_DESC_EX(POS_DESC_EX), .POS_BUF_EX(POS_BUF_EX)
   ) u_map (
      .src_i     (src),
      .set_vec_o (set_vec)
   );

   assign clr_vec = host_wr_i ? (host_wdata_i & WR_MASK) : '0;

   for (genvar b = 0; b < WIDTH; b++) begin : g_cell
      isr_bit_cell u_cell (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .set_i  (set_vec[b]),
         .clr_i  (clr_vec[b]),
         .q_o    (stat_q[b])
      );
   end

   isr_reload_detect #(.ENABLE(RELOAD_ON)) u_reload (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (host_wr_i),
      .wbit_i (host_wdata_i[POS_BUF_EX]),
      .stat_i (stat_q[POS_BUF_EX]),
      .req_o  (rx_reload_o)
   );

   isr_irq_gen #(.WIDTH(WIDTH), .REGISTERED(IRQ_REG)) u_irq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .status_i (stat_q),
      .en_i     (irq_en_i),
      .irq_o    (irq_o)
   );

   assign status_o = stat_q;
endmodule

// File: rtl/isr_status_reg_chk.sv
module isr_status_reg_chk #(
   parameter int unsigned      WIDTH      = 16,
   parameter int unsigned      POS_BUF_EX = 4,
   parameter logic [WIDTH-1:0] WR_MASK    = 16'h001F,
   parameter bit               IRQ_REG    = 1'b1
)(
   input logic             clk,
   input logic             rst_n,
   input logic             wr,
   input logic [WIDTH-1:0] wdata,
   input logic [WIDTH-1:0] set_vec,
   input logic [WIDTH-1:0] en,
   input logic [WIDTH-1:0] status,
   input logic             irq,
   input logic             reload
);
   // R3: written ones on writable bits clear unless a set coincides
   a_r3_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> ((status & $past(wdata & WR_MASK & ~set_vec)) == '0));

   // R4: bits neither cleared nor set keep their value
   a_r4_hold_others: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((status ^ $past(status)) &
                 ~($past(set_vec) | ($past(wr) ? $past(wdata & WR_MASK) : '0))) == '0));

   // R5 / R2: a set pulse always leaves its bit at 1
   a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

   // R6: reload request follows an acknowledge of a set buffers-exhausted bit
   a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (reload == ($past(wr) && $past(wdata[POS_BUF_EX]) &&
                           $past(status[POS_BUF_EX]) && WR_MASK[POS_BUF_EX])));

   if (IRQ_REG) begin : g_irq_reg
      // R7: request lags the masked status by one cycle
      a_r7_irq: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq == $past(|(status & en))));
   end else begin : g_irq_comb
      always_comb begin
         if (rst_n) a_r7_irq_comb: assert (irq == |(status & en));
      end
   end
endmodule

bind isr_status_reg isr_status_reg_chk #(
   .WIDTH(WIDTH), .POS_BUF_EX(POS_BUF_EX), .WR_MASK(WR_MASK), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk     (clk_i),
   .rst_n   (rst_ni),
   .wr      (host_wr_i),
   .wdata   (host_wdata_i),
   .set_vec (set_vec),
   .en      (irq_en_i),
   .status  (status_o),
   .irq     (irq_o),
   .reload  (rx_reload_o)
);

// File: tb/isr_status_reg_test.sv
module isr_status_reg_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic [15:0] wdata = '0;
   logic        s_pkt = 0, s_dex = 0, s_bex = 0, s_txd = 0, s_prg = 0;
   logic [15:0] en = '0;
   logic [15:0] status;
   logic        irq, reload;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 0;

   always #5 clk = ~clk;

   isr_status_reg uut (
      .clk_i(clk), .rst_ni(rst_n), .host_wr_i(wr), .host_wdata_i(wdata),
      .rx_pkt_set_i(s_pkt), .rx_desc_ex_set_i(s_dex), .rx_buf_ex_set_i(s_bex),
      .tx_done_set_i(s_txd), .prog_int_set_i(s_prg), .irq_en_i(en),
      .status_o(status), .irq_o(irq), .rx_reload_o(reload)
   );

   // behavioural reference: bit0 pkt, bit1 txd, bit2 prog, bit3 desc, bit4 buf
   logic [15:0] m_stat = '0;
   logic        m_irq = 0, m_rel = 0;
   always @(posedge clk) begin
      logic [15:0] setv, clrv;
      setv = {11'b0, s_bex, s_dex, s_prg, s_txd, s_pkt};
      clrv = wr ? (wdata & 16'h001F) : 16'h0;
      if (!rst_n) begin
         m_stat = '0; m_irq = 0; m_rel = 0;
      end else begin
         m_rel  = wr && wdata[4] && m_stat[4];
         m_irq  = (m_stat & en) != 0;
         m_stat = (m_stat & ~clrv) | setv;
      end
   end

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
      end
   endtask

   // compare every cycle on the falling edge
   always @(negedge clk) begin
      cyc++;
      if (!done) begin
         check("R2/R3/R4/R5 status", status, m_stat);
         check("R7 irq", {15'b0, irq}, {15'b0, m_irq});
         check("R6 reload", {15'b0, reload}, {15'b0, m_rel});
      end
      if (cyc > 100000 && !done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic step(logic w, logic [15:0] d, logic [4:0] s, logic [15:0] e);
      @(negedge clk);
      #1;
      wr = w; wdata = d; en = e;
      {s_bex, s_dex, s_prg, s_txd, s_pkt} = s;
   endtask

   task automatic idle();
      step(0, 16'h0, 5'b0, en);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #2;
      check("R1 reset status", status, 16'h0);
      check("R1 reset irq", {15'b0, irq}, 16'h0);
      check("R1 reset reload", {15'b0, reload}, 16'h0);
      @(negedge clk); #1 rst_n = 1'b1;

      // R2: each source individually
      for (int i = 0; i < 5; i++) begin
         step(0, 0, 5'(1 << i), 16'h0);
         idle();
         @(negedge clk); #2 check("R2 position", status & 16'(1 << i), 16'(1 << i));
      end
      // R4: zero write and high bits untouched
      step(1, 16'hFFE0, 5'b0, 16'h0);
      idle();
      @(negedge clk); #2 check("R4 keep", status, 16'h001F);
      // R7: enable one bit
      step(0, 0, 5'b0, 16'h0002);
      idle();
      @(negedge clk); #2 check("R7 irq on", {15'b0, irq}, 16'h1);
      // R3: clear bits 0..3
      step(1, 16'h000F, 5'b0, 16'h0002);
      idle();
      @(negedge clk); #2 check("R3 clear", status, 16'h0010);
      // R6 + R5: ack buf-ex while it is set again
      step(1, 16'h0010, 5'b10000, 16'h0);
      @(negedge clk); #2;
      check("R6 reload fires", {15'b0, reload}, 16'h1);
      check("R5 set wins", status, 16'h0010);
      idle();
      @(negedge clk); #2 check("R6 one cycle", {15'b0, reload}, 16'h0);
      // R6: ack with bit set, then ack with bit clear
      step(1, 16'h0010, 5'b0, 16'h0);
      step(1, 16'h0010, 5'b0, 16'h0);
      @(negedge clk); #2 check("R6 no reload when clear", {15'b0, reload}, 16'h0);
      // R8: holding still changes nothing
      repeat (3) idle();
      @(negedge clk); #2 check("R8 stable", status, 16'h0);

      // random mix with frequent coincidences
      for (int n = 0; n < 3000; n++) begin
         step(1'($urandom % 2), 16'($urandom), 5'($urandom & $urandom),
              16'($urandom));
      end
      idle(); idle();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule